// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by fetching one page descriptor from a table that lives in main memory. The upper bits of the virtual address are the virtual page number. The lower bits are the offset within the page. The descriptor sits at the table base plus the page number scaled by the descriptor size. The base comes from a dedicated input that is sampled when a request is accepted.

The block checks the descriptor it fetched. If the page is present and the access is allowed, the physical address is the frame number from the descriptor followed by the untouched offset. The descriptor then goes back to memory with its use bit set, and with its dirty bit set too for a write. The write-back is left out when those bits are already set. A page that is not present gives a page fault. A write to a present page that is marked read-only gives a protection fault. Neither fault writes anything back.

Requests arrive over a valid/ready handshake, and only one translation is in flight at a time. The result comes back as a single-cycle response pulse.

Descriptor layout:
- bit 0: present
- bit 1: use
- bit 2: dirty
- bit 3: write-permitted
- bits 4 upward: the frame number
- remaining upper bits: spare, kept as they are

Top module: `pt_walker`

## Requirements
- R1: For each accepted request, exactly one descriptor read is issued, at address `tbl_base + (VPN << DESC_SHIFT)`. With the defaults, VPN is `req_vaddr[13:10]` and DESC_SHIFT is 1.
- R2: When bit 0 (present) is set and the access is permitted, the response has `rsp_hit`=1. In that case `rsp_paddr` = {descriptor bits [9:4], `req_vaddr[9:0]`}.
- R3: On a hit, exactly one write is issued to the descriptor's address, unless R4 applies. The written word is the fetched descriptor with bit 1 (use) set, and with bit 2 (dirty) set as well when `req_write`=1. All other bits are unchanged, including the spare bits.
- R4: On a hit, no write is issued if bit 1 is already set and, for a write access, bit 2 is also already set.
- R5: When bit 0 is clear, the response has `rsp_page_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0, and no write is issued.
- R6: A write access to a present descriptor with bit 3 clear gives `rsp_prot_fault`=1, `rsp_hit`=0 and no write. A read access to the same descriptor is a normal hit.
- R7: When bit 0 is clear, the page fault is reported even for a write to a descriptor with bit 3 clear, and `rsp_prot_fault` stays 0.
- R8: `req_ready` is low from the cycle after acceptance until `rsp_valid` has pulsed. `rsp_valid` is high for exactly one cycle per request.
- R9: After reset: `req_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0. A reset in the middle of a transaction abandons it.
- R10: While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_page_fault` and `rsp_prot_fault` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 16 | Page table base address, sampled on request accept |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Memory request is a descriptor write-back |
| mem_req_addr | output | 16 | Descriptor address |
| mem_req_wdata | output | 16 | Updated descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 16 | Descriptor read data |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 16 | Physical address |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_page_fault | output | 1 | Page not present |
| rsp_prot_fault | output | 1 | Write to a read-only page |

## Verification
A single fetched descriptor can trigger both the presence check and the protection check in the same decision cycle. The bench provokes this with a write request whose descriptor has both the present bit and the write-permitted bit clear. It judges the result by requiring a page fault with no protection fault and no memory write. The status-bit update and the protection check also meet on one descriptor. A write to a present read-only page with the use bit clear must still produce no write-back. The bench confirms this by counting the memory writes seen between request and response.

// File: rtl/pt_pkg.sv
package pt_pkg;

    // Descriptor bit positions; the write-back and the bench depend on them
    localparam int DSC_PRESENT = 0;
    localparam int DSC_USE     = 1;
    localparam int DSC_DIRTY   = 2;
    localparam int DSC_WPERM   = 3;
    localparam int DSC_PFN_LSB = 4;

    // Default geometry
    localparam int DEF_VPN_W      = 4;
    localparam int DEF_OFF_W      = 10;
    localparam int DEF_PFN_W      = 6;
    localparam int DEF_DESC_W     = 16;
    localparam int DEF_MADDR_W    = 16;
    localparam int DEF_DESC_SHIFT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB_REQ,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic hit;
        logic page_fault;
        logic prot_fault;
        logic need_wb;
    } verdict_t;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_pkg::*;
#(
    parameter int VPN_W      = DEF_VPN_W,
    parameter int MADDR_W    = DEF_MADDR_W,
    parameter int DESC_SHIFT = DEF_DESC_SHIFT
) (
    input  logic [MADDR_W-1:0] base,
    input  logic [VPN_W-1:0]   vpn,
    output logic [MADDR_W-1:0] desc_addr
);
    logic [MADDR_W-1:0] scaled;

    always_comb begin
        scaled    = MADDR_W'(vpn) << DESC_SHIFT;
        desc_addr = base + scaled;
    end
endmodule

// File: rtl/pt_desc_check.sv
module pt_desc_check
    import pt_pkg::*;
#(
    parameter int DESC_W = DEF_DESC_W,
    parameter int PFN_W  = DEF_PFN_W,
    parameter int OFF_W  = DEF_OFF_W
) (
    input  logic [DESC_W-1:0]      desc,
    input  logic                   is_write,
    input  logic [OFF_W-1:0]       offset,
    output verdict_t               verdict,
    output logic [DESC_W-1:0]      desc_upd,
    output logic [PFN_W+OFF_W-1:0] paddr
);
    localparam int PA_W = PFN_W + OFF_W;

    logic present, wperm, refused;
    logic [DESC_W-1:0] set_mask;

    always_comb begin
        present = desc[DSC_PRESENT];
        wperm   = desc[DSC_WPERM];
        // presence is judged first: absent pages never report protection
        refused = present && is_write && !wperm;

        set_mask = '0;
        set_mask[DSC_USE] = 1'b1;
        if (is_write) set_mask[DSC_DIRTY] = 1'b1;
        desc_upd = desc | set_mask;

        verdict.page_fault = !present;
        verdict.prot_fault = refused;
        verdict.hit        = present && !refused;
        verdict.need_wb    = verdict.hit && (desc_upd != desc);

        paddr = verdict.hit ? {desc[DSC_PFN_LSB +: PFN_W], offset} : PA_W'(0);
    end

    // R10
    verdict_onehot_chk: assert final (
        $isunknown(desc) || $countones({verdict.hit, verdict.page_fault, verdict.prot_fault}) == 1);
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import pt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic need_wb,
    output logic req_ready,
    output logic mem_req_valid,
    output logic mem_req_write,
    output logic rsp_valid,
    output logic take_req,
    output logic take_desc
);
    walk_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid)     state_nx = ST_RD_REQ;
            ST_RD_REQ:  if (mem_req_ready) state_nx = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rsp_valid) state_nx = need_wb ? ST_WB_REQ : ST_RESP;
            ST_WB_REQ:  if (mem_req_ready) state_nx = ST_RESP;
            ST_RESP:                       state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ);
        mem_req_write = (state == ST_WB_REQ);
        rsp_valid     = (state == ST_RESP);
        take_req      = req_ready && req_valid;
        take_desc     = (state == ST_RD_WAIT) && mem_rsp_valid;
    end

    // R8
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);

    // R8
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (rst)
        take_req |=> !req_ready && mem_req_valid && !mem_req_write);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
#(
    parameter int VPN_W      = DEF_VPN_W,
    parameter int OFF_W      = DEF_OFF_W,
    parameter int PFN_W      = DEF_PFN_W,
    parameter int DESC_W     = DEF_DESC_W,
    parameter int MADDR_W    = DEF_MADDR_W,
    parameter int DESC_SHIFT = DEF_DESC_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [MADDR_W-1:0]     tbl_base,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    input  logic                   req_write,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic                   mem_req_write,
    output logic [MADDR_W-1:0]     mem_req_addr,
    output logic [DESC_W-1:0]      mem_req_wdata,
    input  logic                   mem_rsp_valid,
    input  logic [DESC_W-1:0]      mem_rsp_rdata,
    output logic                   rsp_valid,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic                   rsp_hit,
    output logic                   rsp_page_fault,
    output logic                   rsp_prot_fault
);
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PFN_W + OFF_W;

    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [MADDR_W-1:0] base_q;
    logic [DESC_W-1:0]  wdata_q;
    logic [PA_W-1:0]    paddr_q;
    verdict_t           verdict_q;

    logic               take_req, take_desc;
    verdict_t           verdict;
    logic [DESC_W-1:0]  desc_upd;
    logic [PA_W-1:0]    paddr_c;

    pt_ctrl i_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .need_wb       (verdict.need_wb),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .rsp_valid     (rsp_valid),
        .take_req      (take_req),
        .take_desc     (take_desc)
    );

    pt_addr_gen #(
        .VPN_W      (VPN_W),
        .MADDR_W    (MADDR_W),
        .DESC_SHIFT (DESC_SHIFT)
    ) i_addr (
        .base      (base_q),
        .vpn       (va_q[VA_W-1 -: VPN_W]),
        .desc_addr (mem_req_addr)
    );

    pt_desc_check #(
        .DESC_W (DESC_W),
        .PFN_W  (PFN_W),
        .OFF_W  (OFF_W)
    ) i_check (
        .desc     (mem_rsp_rdata),
        .is_write (wr_q),
        .offset   (va_q[OFF_W-1:0]),
        .verdict  (verdict),
        .desc_upd (desc_upd),
        .paddr    (paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q      <= '0;
            wr_q      <= 1'b0;
            base_q    <= '0;
            wdata_q   <= '0;
            paddr_q   <= '0;
            verdict_q <= '0;
        end else begin
            if (take_req) begin
                va_q   <= req_vaddr;
                wr_q   <= req_write;
                base_q <= tbl_base;
            end
            if (take_desc) begin
                wdata_q   <= desc_upd;
                paddr_q   <= paddr_c;
                verdict_q <= verdict;
            end
        end
    end

    assign mem_req_wdata  = wdata_q;
    assign rsp_paddr      = paddr_q;
    assign rsp_hit        = verdict_q.hit;
    assign rsp_page_fault = verdict_q.page_fault;
    assign rsp_prot_fault = verdict_q.prot_fault;

    // R3
    wb_marks_use_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> mem_req_wdata[DSC_PRESENT] && mem_req_wdata[DSC_USE]);

    // R1
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    // R2
    offset_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

    // R10
    rsp_flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_page_fault, rsp_prot_fault}) == 1);

    // R5
    fault_paddr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_paddr == '0);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tbl_base;
    logic        req_valid;
    logic        req_ready;
    logic [13:0] req_vaddr;
    logic        req_write;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [15:0] mem_req_addr;
    logic [15:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_rdata;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_hit, rsp_page_fault, rsp_prot_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault)
    );

    // Memory model: one table image indexed by VPN, stalls from a rotating pattern
    logic [15:0] tbl_img [16];
    logic [7:0]  rdy_pat;
    int          rd_cnt, wr_cnt;
    logic [15:0] last_rd_addr, last_wr_addr, last_wr_data;

    assign mem_req_ready = rdy_pat[0];

    always @(posedge clk) begin
        if (rst) begin
            rdy_pat       <= 8'b1011_0110;
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
        end else begin
            rdy_pat       <= {rdy_pat[0], rdy_pat[7:1]};
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= mem_req_addr;
                    last_wr_data <= mem_req_wdata;
                end else begin
                    rd_cnt        <= rd_cnt + 1;
                    last_rd_addr  <= mem_req_addr;
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= tbl_img[4'((mem_req_addr - tbl_base) >> 1)];
                end
            end
        end
    end

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 hit, 1 page fault, 2 protection fault
    typedef struct packed {
        logic [13:0] va;
        logic        wr;
        logic [15:0] desc;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{14'h0AAB, 1'b0, 16'h0059, 2'd0},  // plain read hit, U set on write-back
        '{14'h1C01, 1'b1, 16'h03F9, 2'd0},  // write hit, U and D set
        '{14'h0C10, 1'b1, 16'h0058, 2'd1},  // absent page
        '{14'h1000, 1'b1, 16'h0011, 2'd2},  // write to read-only page, U clear
        '{14'h1000, 1'b0, 16'h0011, 2'd0},  // read of read-only page
        '{14'h1555, 1'b0, 16'h0023, 2'd0},  // U already set, read: no write-back
        '{14'h1555, 1'b1, 16'h002B, 2'd0},  // U set, D clear, write: write-back
        '{14'h1BFF, 1'b1, 16'h009F, 2'd0},  // U and D set, write: no write-back
        '{14'h0400, 1'b1, 16'h0010, 2'd1},  // absent and read-only write
        '{14'h3FFF, 1'b0, 16'hFC35, 2'd0},  // spare bits kept
        '{14'h0000, 1'b0, 16'h0001, 2'd0}   // page 0, offset 0
    };

    task automatic run_vec(input vec_t v, input logic [15:0] base);
        int rd0, wr0, guard;
        logic [3:0]  vpn;
        logic [15:0] exp_addr, exp_wd, exp_pa;
        logic        exp_wb;
        logic [2:0]  exp_flags;
        vpn      = v.va[13:10];
        exp_addr = base + {11'd0, vpn, 1'b0};
        exp_wd   = v.desc | 16'h0002 | (v.wr ? 16'h0004 : 16'h0000);
        exp_wb   = (v.kind == 2'd0) && (exp_wd != v.desc);
        exp_pa   = (v.kind == 2'd0) ? {v.desc[9:4], v.va[9:0]} : 16'h0000;
        exp_flags = (v.kind == 2'd0) ? 3'b001 : (v.kind == 2'd1) ? 3'b010 : 3'b100;
        tbl_img[vpn] = v.desc;
        tbl_base  = base;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_write = v.wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 busy after accept", 32'(req_ready), 32'd0);
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid, "R8 response arrives", 32'(rsp_valid), 32'd1);
        chk(rd_cnt - rd0 == 1, "R1 one descriptor read", 32'(rd_cnt - rd0), 32'd1);
        chk(last_rd_addr == exp_addr, "R1 descriptor address", 32'(last_rd_addr), 32'(exp_addr));
        chk({rsp_prot_fault, rsp_page_fault, rsp_hit} == exp_flags, "R2/R5/R6/R7/R10 flags",
            32'({rsp_prot_fault, rsp_page_fault, rsp_hit}), 32'(exp_flags));
        chk(rsp_paddr == exp_pa, "R2 physical address", 32'(rsp_paddr), 32'(exp_pa));
        chk((wr_cnt - wr0) == int'(exp_wb), "R3/R4 write-back count", 32'(wr_cnt - wr0), 32'(exp_wb));
        if (exp_wb) begin
            chk(last_wr_data == exp_wd, "R3 updated descriptor", 32'(last_wr_data), 32'(exp_wd));
            chk(last_wr_addr == exp_addr, "R3 write-back address", 32'(last_wr_addr), 32'(exp_addr));
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R8 single pulse then ready",
            32'({rsp_valid, req_ready}), 32'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rd_cnt = 0; wr_cnt = 0;
        last_rd_addr = '0; last_wr_addr = '0; last_wr_data = '0;
        for (int k = 0; k < 16; k++) tbl_img[k] = 16'h0000;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; tbl_base = 16'h0100;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready && !mem_req_valid && !rsp_valid, "R9 reset outputs",
            32'({req_ready, mem_req_valid, rsp_valid}), 32'b100);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            run_vec(VECS[i], 16'h0100 + 16'(i * 64));

        // Address-space example: small page number with zero frame maps to offset only
        run_vec('{14'h0802, 1'b1, 16'h0009, 2'd0}, 16'h7FF0);

        // R9 reset in the middle of a translation
        tbl_img[3] = 16'h0041;
        req_valid = 1'b1; req_vaddr = 14'h0C00; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R9 reset abandons",
            32'({req_ready, mem_req_valid, rsp_valid}), 32'b100);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 no stale response",
            32'({rsp_valid, req_ready}), 32'b01);

        // Traffic continues normally after the abort
        run_vec('{14'h2C7F, 1'b1, 16'h00E9, 2'd0}, 16'h0200);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule